// File: doc/BRIEF.md
# Bidirectional Serial Column Driver Logic

This block is the logic front end of a 40-channel display column driver. A serial bit stream enters on one of two data pins. It is shifted through a 40-stage register, one stage per falling edge of a serial clock. The serial clock is sampled by the block's system clock. A direction input picks which pin receives data and which pin repeats the far end of the register, so that several drivers can be chained in either direction.

A parallel holding stage sits behind the register. It follows the register while the strobe is low and freezes while the strobe is high. A per-channel output stage then either forces all channels to one level (blank) or passes the held word through, inverted or not, as the polarity input selects.

Each data pin is modelled as a separate input, output and output-enable. The enables come straight from the direction input.

Top module: `sdrv_column`

## Requirements
- R1: The shift register changes only in a cycle where a falling edge of `sclk_i` is seen. A falling edge is `sclk_i` low now while it was high at the previous system clock edge. With no falling edge, the contents stay unchanged whatever the data pins do.
- R2: With `dir_i` = 1, a falling edge loads `a_in_i` into stage 1 and moves each stage k to stage k+1. `b_out_o` shows stage 40 and `b_oe_o` = 1.
- R3: With `dir_i` = 0, a falling edge loads `b_in_i` into stage 40 and moves each stage k to stage k-1. `a_out_o` shows stage 1 and `a_oe_o` = 1.
- R4: While `stb_i` is low, the held word equals the current shift register contents (transparent).
- R5: While `stb_i` is high, the held word keeps the value it had at the last system clock edge where `stb_i` was low.
- R6: With `blank_i` = 1, every bit of `drv_o` equals `pol_i`, regardless of the held word.
- R7: With `blank_i` = 0, `drv_o[k-1]` equals held bit k when `pol_i` = 1, and its inverse when `pol_i` = 0. Stage k maps to bit k-1 of every 40-bit vector.
- R8: The pin used as input has its enable low: `a_oe_o` = `~dir_i` and `b_oe_o` = `dir_i`, combinationally.
- R9: Synchronous reset `rst` clears the shift register and the held word, and forgets any earlier high level on `sclk_i`.
- R10: Suppose `stb_i` rises in the same cycle in which a falling edge is seen. The held word is then the register contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| sclk_i | input | 1 | serial shift clock, falling edge active |
| dir_i | input | 1 | 1: A in, shift toward stage 40; 0: B in, shift toward stage 1 |
| a_in_i | input | 1 | pin A input value |
| a_out_o | output | 1 | pin A driven value (stage 1) |
| a_oe_o | output | 1 | pin A driver enable |
| b_in_i | input | 1 | pin B input value |
| b_out_o | output | 1 | pin B driven value (stage 40) |
| b_oe_o | output | 1 | pin B driver enable |
| stb_i | input | 1 | strobe, low = transparent, high = hold |
| blank_i | input | 1 | force all channels to `pol_i` |
| pol_i | input | 1 | 1: true polarity, 0: inverted |
| drv_o | output | 40 | channel controls, bit k-1 for channel k |

## Verification
A shift and a strobe change can fall in the same system clock cycle. The bench provokes this in two ways. It raises the strobe on the very cycle a falling serial edge is seen, and it shifts while the strobe is held low. A queue-based reference model follows the same cycle rules and predicts which of the two register words the holding stage shows. The outputs are compared with that model on every clock. The blank and polarity inputs are also changed in the same cycles as shifts, so that the forced level and the inversion are judged against a word that is still moving.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;
  typedef enum logic {DIR_TOWARD_FIRST = 1'b0, DIR_TOWARD_LAST = 1'b1} sdir_e;

  // level of one channel from its held bit, blank and polarity
  function automatic logic chan_level(input logic held, input logic blank, input logic pol);
    if (blank) return pol;
    return pol ? held : ~held;
  endfunction

  // one step of the shift chain in the chosen direction
  function automatic logic [39:0] step40(input logic [39:0] cur, input sdir_e dir,
                                         input logic a_in, input logic b_in);
    if (dir == DIR_TOWARD_LAST) return {cur[38:0], a_in};
    return {b_in, cur[39:1]};
  endfunction
endpackage

// File: rtl/sdrv_edge.sv
module sdrv_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_i;
  end

  assign fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/sdrv_shift.sv
module sdrv_shift #(
  parameter int NCH = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fall_i,
  input  logic           dir_i,
  input  logic           a_in_i,
  input  logic           b_in_i,
  output logic [NCH-1:0] sr_o
);
  import sdrv_pkg::*;
  localparam int LAST = NCH - 1;

  logic [NCH-1:0] sr_q;
  logic [NCH-1:0] sr_next;

  generate
    if (NCH == 40) begin : g_fixed
      assign sr_next = step40(sr_q, sdir_e'(dir_i), a_in_i, b_in_i);
    end else begin : g_generic
      assign sr_next = dir_i ? {sr_q[LAST-1:0], a_in_i} : {b_in_i, sr_q[LAST:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         sr_q <= '0;
    else if (fall_i) sr_q <= sr_next;
  end

  assign sr_o = sr_q;

  AST_NO_SHIFT_WITHOUT_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_i |=> $stable(sr_q)); // R1
  AST_RIGHT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (fall_i && dir_i) |=> (sr_q[0] == $past(a_in_i) && sr_q[LAST] == $past(sr_q[LAST-1]))); // R2
  AST_LEFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !dir_i) |=> (sr_q[LAST] == $past(b_in_i) && sr_q[0] == $past(sr_q[1]))); // R3
endmodule

// File: rtl/sdrv_hold.sv
module sdrv_hold #(
  parameter int NCH = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb_i,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] view_o
);
  logic [NCH-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (!stb_i) held_q <= d_i;
  end

  assign view_o = stb_i ? held_q : d_i;

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stb_i |=> (stb_i -> $stable(view_o))); // R5
  AST_RISE_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (!stb_i) |=> (stb_i -> view_o == $past(d_i))); // R10
endmodule

// File: rtl/sdrv_outstage.sv
module sdrv_outstage #(
  parameter int NCH = 40
) (
  input  logic [NCH-1:0] held_i,
  input  logic           blank_i,
  input  logic           pol_i,
  output logic [NCH-1:0] drv_o
);
  import sdrv_pkg::*;

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_chan
      assign drv_o[k] = chan_level(held_i[k], blank_i, pol_i);
    end
  endgenerate

  always_comb begin
    if (blank_i) AST_BLANK_UNIFORM: assert ($countones(drv_o) == (pol_i ? NCH : 0)); // R6
    else         AST_POL_RELATION: assert ((drv_o ^ held_i) == {NCH{~pol_i}}); // R7
  end
endmodule

// File: rtl/sdrv_column.sv
module sdrv_column #(
  parameter int NCH = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sclk_i,
  input  logic           dir_i,
  input  logic           a_in_i,
  output logic           a_out_o,
  output logic           a_oe_o,
  input  logic           b_in_i,
  output logic           b_out_o,
  output logic           b_oe_o,
  input  logic           stb_i,
  input  logic           blank_i,
  input  logic           pol_i,
  output logic [NCH-1:0] drv_o
);
  logic           shift_fall;
  logic [NCH-1:0] chain_word;
  logic [NCH-1:0] held_word;

  sdrv_edge u_edge (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .fall_o(shift_fall)
  );

  sdrv_shift #(.NCH(NCH)) u_shift (
    .clk(clk), .rst(rst), .fall_i(shift_fall), .dir_i(dir_i),
    .a_in_i(a_in_i), .b_in_i(b_in_i), .sr_o(chain_word)
  );

  sdrv_hold #(.NCH(NCH)) u_hold (
    .clk(clk), .rst(rst), .stb_i(stb_i), .d_i(chain_word), .view_o(held_word)
  );

  sdrv_outstage #(.NCH(NCH)) u_out (
    .held_i(held_word), .blank_i(blank_i), .pol_i(pol_i), .drv_o(drv_o)
  );

  assign a_oe_o  = ~dir_i;
  assign b_oe_o  = dir_i;
  assign a_out_o = chain_word[0];
  assign b_out_o = chain_word[NCH-1];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (chain_word == '0 && (stb_i || held_word == '0))); // R9
  AST_PIN_ROLES: assert property (@(posedge clk) disable iff (rst)
    (a_oe_o != b_oe_o) && (b_oe_o == dir_i)); // R8
endmodule

// File: tb/sdrv_column_bench.sv
module sdrv_column_bench;
  localparam int N = 40;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, dir = 1'b1, a_in = 1'b0, b_in = 1'b0;
  logic stb = 1'b1, blank = 1'b0, pol = 1'b1;
  logic a_out, a_oe, b_out, b_oe;
  logic [N-1:0] drv;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdrv_column u_sdrv_column (
    .clk(clk), .rst(rst), .sclk_i(sclk), .dir_i(dir), .a_in_i(a_in), .a_out_o(a_out),
    .a_oe_o(a_oe), .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe), .stb_i(stb),
    .blank_i(blank), .pol_i(pol), .drv_o(drv)
  );

  // reference model: queue index i is stage i+1
  bit mq[$];
  bit mheld[N];
  bit mprev;

  initial begin
    for (int i = 0; i < N; i++) begin mq.push_back(1'b0); mheld[i] = 1'b0; end
    mprev = 1'b0;
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin mq[i] = 1'b0; mheld[i] = 1'b0; end
      mprev = 1'b0;
    end else begin
      if (!stb) for (int i = 0; i < N; i++) mheld[i] = mq[i];
      if (mprev && !sclk) begin
        if (dir) begin mq.push_front(a_in); void'(mq.pop_back()); end
        else     begin mq.push_back(b_in);  void'(mq.pop_front()); end
      end
      mprev = sclk;
    end
  end

  function automatic logic [N-1:0] exp_view();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = stb ? mheld[i] : mq[i];
    return v;
  endfunction

  function automatic logic [N-1:0] exp_drv();
    logic [N-1:0] v = exp_view();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = blank ? pol : ~(v[i] ^ pol);
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      chk(drv === exp_drv(), blank ? "R6 blank" : "R7 polarity", drv, exp_drv());
      chk(a_oe === ~dir && b_oe === dir, "R8 pin enables", {a_oe, b_oe}, {~dir, dir});
      if (dir) chk(b_out === mq[N-1], "R2 cascade B", b_out, mq[N-1]);
      else     chk(a_out === mq[0], "R3 cascade A", a_out, mq[0]);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic shift_bit(input bit d);
    if (dir) a_in = d; else b_in = d;
    sclk = 1'b1; tick();
    sclk = 1'b0; tick();
  endtask

  task automatic shift_word(input logic [N-1:0] w);
    // right mode: bit N-1 first so that w lands as-is; left mode: bit 0 first
    for (int i = 0; i < N; i++) shift_bit(dir ? w[N-1-i] : w[i]);
  endtask

  logic [N-1:0] p1 = 40'hA5_0F3C_9671;
  logic [N-1:0] p2 = 40'h1E_C3B4_0F58;
  logic [N-1:0] snap;

  initial begin
    tick(); tick();
    rst = 1'b0; stb = 1'b0; tick(); #1;
    chk(drv === '0, "R9 reset clears", drv, '0);
    stb = 1'b1;

    // R2: right shift with strobe high, held word stays zero (R5)
    dir = 1'b1; shift_word(p1); #1;
    chk(drv === '0, "R5 hold while strobe high", drv, '0);
    stb = 1'b0; tick(); #1;
    chk(drv === p1, "R4 transparent shows R2 right-shift word", drv, p1);
    stb = 1'b1; tick();

    // R3: left shift, held word must remain p1
    dir = 1'b0; shift_word(p2); #1;
    chk(drv === p1, "R5 hold during left shift", drv, p1);
    stb = 1'b0; tick(); #1;
    chk(drv === p2, "R3 left-shift word latched", drv, p2);

    // R1: data toggles, clock held high / low, no falling edge
    sclk = 1'b1; b_in = 1'b1; tick(); b_in = 1'b0; tick(); a_in = 1'b1; tick(); #1;
    chk(drv === p2, "R1 no shift with clock high", drv, p2);
    sclk = 1'b1; tick(); #1;
    chk(drv === p2, "R1 no shift on clock still high", drv, p2);
    sclk = 1'b0; tick();

    // R6/R7: all four blank/polarity combinations
    blank = 1'b0; pol = 1'b0; tick(); #1;
    chk(drv === ~exp_view(), "R7 inverted", drv, ~exp_view());
    blank = 1'b1; pol = 1'b0; tick(); #1;
    chk(drv === '0, "R6 blank low", drv, '0);
    blank = 1'b1; pol = 1'b1; tick(); #1;
    chk(drv === '1, "R6 blank high", drv, '1);
    blank = 1'b0; pol = 1'b1; tick(); #1;
    chk(drv === exp_view(), "R7 true polarity", drv, exp_view());

    // R10: strobe rises on the cycle the falling edge is seen
    dir = 1'b1; a_in = 1'b1; sclk = 1'b1; tick();
    snap = exp_view();
    sclk = 1'b0; stb = 1'b1; tick(); #1;
    chk(drv === snap, "R10 strobe rise keeps pre-shift word", drv, snap);
    stb = 1'b0; tick(); #1;
    chk(drv === {snap[N-2:0], 1'b1}, "R4 shifted word visible after release", drv, {snap[N-2:0], 1'b1});

    // shifting while transparent, with blank toggling mid-stream
    pol = 1'b0;
    for (int i = 0; i < 12; i++) begin
      blank = i[1];
      shift_bit(i[0] ^ i[2]);
    end
    blank = 1'b0; dir = 1'b0;
    for (int i = 0; i < 12; i++) shift_bit(i[0]);

    // R9: reset mid-operation
    sclk = 1'b1; rst = 1'b1; tick();
    rst = 1'b0; sclk = 1'b0; tick(); #1;
    chk(drv === '1, "R9 reset clears (inverted view)", drv, '1);
    tick();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule